// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a single-port synchronous memory with a shared data bus. It accepts a read or a write command on every enabled clock edge, in any mix. Write data follows its command by a fixed two-edge lag, and read data is driven over the same bus slot. Because of this alignment, the bus changes direction between reads and writes without idle cycles. Words are split into byte lanes, and each lane has its own write select.

A write command passes through two address registers while its data is on the way. The captured data then waits in a one-entry buffer, and only the next write commits it to the array. A forwarding path gives reads the newest value held in three places: the array, the buffered write and the write whose data is on the bus at that moment. It merges them lane by lane.

A low-active clock enable freezes the whole pipeline. A load/advance input lets a command continue as a short linear burst. An asynchronous low-active output enable gates the bus driver.

Top module: `zt_sram`

## Requirements
- R1: A command is accepted on a load edge only when cs1_ni=0, cs2_i=1 and cs3_ni=0. In any other case the edge is an idle cycle: nothing is written and the bus is not driven in its slot.
- R2: A read captured at enabled edge E drives the addressed word on dq_o with dq_oe_o=1. This happens throughout the cycle that follows the next enabled edge, so the value can be sampled at the second enabled edge after E.
- R3: For a write captured at enabled edge E, dq_i is sampled at the second enabled edge after E, and dq_oe_o stays 0 during that data cycle.
- R4: Reads and writes may follow each other on consecutive edges in any order. Every read returns the contents as left by all earlier commands, including writes not yet committed to the array.
- R5: Lane l occupies dq bits [9l+8:9l], with lane 0 at bits 8:0. A write changes lane l only when lane_we_ni[l]=0 on its command edge and leaves the other lane intact. A write with lane_we_ni=2'b11 changes nothing.
- R6: When two pending writes to the same address enable different lanes, a following read returns each lane from the newest write that enabled it.
- R7: While clk_en_ni=1, edges are ignored. Commands, pipeline state, dq_o and dq_oe_o all hold, and the current bus slot is extended.
- R8: out_en_ni=1 forces dq_oe_o to 0 at once, without changing the pipeline or later reads.
- R9: With load_ni=1, the previous command type (read, write or idle) is repeated at an address whose two low bits are incremented modulo 4 while the upper bits are kept. The lane selects are sampled again on every beat.
- R10: After reset, dq_o is 0, dq_oe_o is 0 and the pipeline is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_ni | input | 1 | Clock enable, active low |
| cs1_ni | input | 1 | Chip select, active low |
| cs2_i | input | 1 | Chip select, active high |
| cs3_ni | input | 1 | Chip select, active low |
| load_ni | input | 1 | 0 loads a new command, 1 advances the burst |
| we_ni | input | 1 | Write enable, active low, sampled on load |
| lane_we_ni | input | LANES | Per-lane write selects, active low |
| addr_i | input | ADDR_W | Word address |
| dq_i | input | WORD_W | Bus input side |
| dq_o | output | WORD_W | Bus output side, registered |
| dq_oe_o | output | 1 | Bus driver enable |
| out_en_ni | input | 1 | Asynchronous output enable, active low |

## Verification
The main function is exercised with several command patterns:
- Back-to-back writes followed by reads, which separate the read slot from the write data slot.
- Strict read/write alternation, and a read issued one edge after a write to the same address. These tell apart forwarding from the live bus, forwarding from the buffered write, and plain array reads.
- Pairs of partial-lane writes to one address, which expose which lane takes priority in the merge.
- Stalls placed inside both read slots and write slots, which show that the slot is extended rather than shifted.
- Burst sequences that start near the end of a four-word group, which reveal whether the address wraps or carries into the upper bits.

// File: rtl/zt_sram_pkg.sv
`timescale 1ns/1ps
package zt_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/zt_cmd_pipe.sv
`timescale 1ns/1ps
module zt_cmd_pipe
  import zt_sram_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned LANES   = 2,
  parameter int unsigned BURST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sel_i,
  input  logic              load_i,
  input  logic              wr_i,
  input  logic [LANES-1:0]  lane_wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output op_e               s1_op_o,
  output logic [ADDR_W-1:0] s1_addr_o,
  output op_e               s2_op_o,
  output logic [ADDR_W-1:0] s2_addr_o,
  output logic [LANES-1:0]  s2_lanes_o
);
  op_e               s1_op_q, s2_op_q, nx_op;
  logic [ADDR_W-1:0] s1_addr_q, s2_addr_q, nx_addr;
  logic [LANES-1:0]  s1_lanes_q, s2_lanes_q;

  always_comb begin
    if (load_i) begin
      nx_op   = sel_i ? (wr_i ? OP_WRITE : OP_READ) : OP_IDLE;
      nx_addr = addr_i;
    end else begin
      // burst beat: linear wrap inside the low address bits
      nx_op   = s1_op_q;
      nx_addr = {s1_addr_q[ADDR_W-1:BURST_W], BURST_W'(s1_addr_q[BURST_W-1:0] + 1'b1)};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_op_q    <= OP_IDLE;
      s1_addr_q  <= '0;
      s1_lanes_q <= '0;
      s2_op_q    <= OP_IDLE;
      s2_addr_q  <= '0;
      s2_lanes_q <= '0;
    end else if (en_i) begin
      s1_op_q    <= nx_op;
      s1_addr_q  <= nx_addr;
      s1_lanes_q <= lane_wr_i;
      s2_op_q    <= s1_op_q;
      s2_addr_q  <= s1_addr_q;
      s2_lanes_q <= s1_lanes_q;
    end
  end

  assign s1_op_o    = s1_op_q;
  assign s1_addr_o  = s1_addr_q;
  assign s2_op_o    = s2_op_q;
  assign s2_addr_o  = s2_addr_q;
  assign s2_lanes_o = s2_lanes_q;

  // R3
  s2_follows_s1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (s2_op_q == $past(s1_op_q) && s2_addr_q == $past(s1_addr_q)));

  // R9
  burst_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i) |=> (s1_op_q == $past(s1_op_q) &&
      s1_addr_q == {$past(s1_addr_q[ADDR_W-1:BURST_W]),
                    BURST_W'($past(s1_addr_q[BURST_W-1:0]) + 1'b1)}));
endmodule

// File: rtl/zt_mem_array.sv
`timescale 1ns/1ps
module zt_mem_array #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned WORD_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [LANES-1:0]  wr_lanes_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] cell_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_lanes_i[l]) cell_q[wr_addr_i] <= wr_data_i[l*LANE_W +: LANE_W];
    end

    assign rd_data_o[l*LANE_W +: LANE_W] = cell_q[rd_addr_i];
  end
endmodule

// File: rtl/zt_wbuf.sv
`timescale 1ns/1ps
module zt_wbuf #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned WORD_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cap_i,
  input  logic [ADDR_W-1:0] cap_addr_i,
  input  logic [LANES-1:0]  cap_lanes_i,
  input  logic [WORD_W-1:0] cap_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [WORD_W-1:0] arr_data_i,
  output logic              commit_o,
  output logic [ADDR_W-1:0] commit_addr_o,
  output logic [LANES-1:0]  commit_lanes_o,
  output logic [WORD_W-1:0] commit_data_o,
  output logic [WORD_W-1:0] fwd_data_o
);
  logic              pend_vld_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [LANES-1:0]  pend_lanes_q;
  logic [WORD_W-1:0] pend_data_q;
  logic              hit_new, hit_old;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_vld_q   <= 1'b0;
      pend_addr_q  <= '0;
      pend_lanes_q <= '0;
      pend_data_q  <= '0;
    end else if (en_i && cap_i) begin
      pend_vld_q   <= 1'b1;
      pend_addr_q  <= cap_addr_i;
      pend_lanes_q <= cap_lanes_i;
      pend_data_q  <= cap_data_i;
    end
  end

  // older pending write retires when the next write's data lands
  assign commit_o       = en_i & cap_i & pend_vld_q;
  assign commit_addr_o  = pend_addr_q;
  assign commit_lanes_o = pend_lanes_q;
  assign commit_data_o  = pend_data_q;

  assign hit_new = cap_i && (cap_addr_i == rd_addr_i);
  assign hit_old = pend_vld_q && (pend_addr_q == rd_addr_i);

  for (genvar l = 0; l < LANES; l++) begin : g_fwd
    always_comb begin
      if (hit_new && cap_lanes_i[l])
        fwd_data_o[l*LANE_W +: LANE_W] = cap_data_i[l*LANE_W +: LANE_W];
      else if (hit_old && pend_lanes_q[l])
        fwd_data_o[l*LANE_W +: LANE_W] = pend_data_q[l*LANE_W +: LANE_W];
      else
        fwd_data_o[l*LANE_W +: LANE_W] = arr_data_i[l*LANE_W +: LANE_W];
    end
  end

  // R4
  pend_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_vld_q |=> pend_vld_q);
endmodule

// File: rtl/zt_sram.sv
`timescale 1ns/1ps
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned WORD_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_ni,
  input  logic              cs1_ni,
  input  logic              cs2_i,
  input  logic              cs3_ni,
  input  logic              load_ni,
  input  logic              we_ni,
  input  logic [LANES-1:0]  lane_we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] dq_i,
  output logic [WORD_W-1:0] dq_o,
  output logic              dq_oe_o,
  input  logic              out_en_ni
);
  logic              en, sel;
  op_e               s1_op, s2_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [LANES-1:0]  s2_lanes;
  logic              commit;
  logic [ADDR_W-1:0] commit_addr;
  logic [LANES-1:0]  commit_lanes;
  logic [WORD_W-1:0] commit_data, arr_rd, fwd;
  logic [WORD_W-1:0] dout_q;
  logic              drive_q;

  assign en  = ~clk_en_ni;
  assign sel = ~cs1_ni & cs2_i & ~cs3_ni;

  zt_cmd_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .BURST_W(2)) u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .sel_i      (sel),
    .load_i     (~load_ni),
    .wr_i       (~we_ni),
    .lane_wr_i  (~lane_we_ni),
    .addr_i     (addr_i),
    .s1_op_o    (s1_op),
    .s1_addr_o  (s1_addr),
    .s2_op_o    (s2_op),
    .s2_addr_o  (s2_addr),
    .s2_lanes_o (s2_lanes)
  );

  zt_wbuf #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wbuf (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .en_i           (en),
    .cap_i          (s2_op == OP_WRITE),
    .cap_addr_i     (s2_addr),
    .cap_lanes_i    (s2_lanes),
    .cap_data_i     (dq_i),
    .rd_addr_i      (s1_addr),
    .arr_data_i     (arr_rd),
    .commit_o       (commit),
    .commit_addr_o  (commit_addr),
    .commit_lanes_o (commit_lanes),
    .commit_data_o  (commit_data),
    .fwd_data_o     (fwd)
  );

  zt_mem_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk_i      (clk_i),
    .wr_en_i    (commit),
    .wr_addr_i  (commit_addr),
    .wr_lanes_i (commit_lanes),
    .wr_data_i  (commit_data),
    .rd_addr_i  (s1_addr),
    .rd_data_o  (arr_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q  <= '0;
      drive_q <= 1'b0;
    end else if (en) begin
      drive_q <= (s1_op == OP_READ);
      if (s1_op == OP_READ) dout_q <= fwd;
    end
  end

  assign dq_o    = dout_q;
  assign dq_oe_o = drive_q & ~out_en_ni;

  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_ni |=> ($stable(dout_q) && $stable(drive_q)));

  // R3
  no_drive_in_wr_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s2_op == OP_WRITE) |-> !drive_q);

  // R1
  deselect_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !load_ni && !sel) |=> (s1_op == OP_IDLE));
endmodule

// File: tb/zt_sram_tb.sv
`timescale 1ns/1ps
module zt_sram_tb;
  typedef enum int {K_IDLE, K_RD, K_WR} kind_e;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clk_en_ni = 1'b0;
  logic        cs1_ni = 1'b1, cs2_i = 1'b1, cs3_ni = 1'b0;
  logic        load_ni = 1'b0, we_ni = 1'b1;
  logic [1:0]  lane_we_ni = 2'b11;
  logic [7:0]  addr_i = '0;
  logic [17:0] dq_i = '0;
  logic [17:0] dq_o;
  logic        dq_oe_o;
  logic        out_en_ni = 1'b0;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [17:0] model [256];
  kind_e       p0_k = K_IDLE, p1_k = K_IDLE, last_k = K_IDLE;
  logic [7:0]  p0_a = '0, p1_a = '0, last_a = '0;
  logic [17:0] p0_d = '0, p1_d = '0;
  string       p0_t = "R10", p1_t = "R10";

  always #2.5 clk = ~clk;

  zt_sram u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .clk_en_ni(clk_en_ni),
    .cs1_ni(cs1_ni), .cs2_i(cs2_i), .cs3_ni(cs3_ni),
    .load_ni(load_ni), .we_ni(we_ni), .lane_we_ni(lane_we_ni),
    .addr_i(addr_i), .dq_i(dq_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o),
    .out_en_ni(out_en_ni)
  );

  task automatic chk(bit ok, string tag, logic [17:0] act, logic [17:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock slot: check the bus slot of the command two enabled edges back, then present a new command
  task automatic step(bit en, bit ld, bit c1n, bit c2, bit c3n, bit w, logic [1:0] ln,
                      logic [7:0] ad, logic [17:0] d, bit oen, string tag);
    kind_e k;
    logic [7:0] a;
    logic [17:0] v;
    @(negedge clk);
    out_en_ni = oen;
    dq_i = (p1_k == K_WR) ? p1_d : 18'h0;
    #1;
    if (p1_k == K_RD) begin
      chk(dq_oe_o == !oen, p1_t, {17'b0, dq_oe_o}, {17'b0, !oen});
      if (!oen) chk(dq_o === p1_d, p1_t, dq_o, p1_d);
    end else begin
      chk(dq_oe_o == 1'b0, p1_t, {17'b0, dq_oe_o}, 18'h0);
    end
    clk_en_ni = !en; load_ni = !ld; cs1_ni = c1n; cs2_i = c2; cs3_ni = c3n;
    we_ni = !w; lane_we_ni = ln; addr_i = ad;
    if (ld) begin
      k = (!c1n && c2 && !c3n) ? (w ? K_WR : K_RD) : K_IDLE;
      a = ad;
    end else begin
      k = last_k;
      a = {last_a[7:2], last_a[1:0] + 2'd1};
    end
    if (en) begin
      v = d;
      if (k == K_WR)
        for (int l = 0; l < 2; l++) if (!ln[l]) model[a][l*9 +: 9] = d[l*9 +: 9];
      if (k == K_RD) v = model[a];
      p1_k = p0_k; p1_a = p0_a; p1_d = p0_d; p1_t = p0_t;
      p0_k = k;    p0_a = a;    p0_d = v;    p0_t = tag;
      last_k = k;  last_a = a;
    end
    @(posedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [17:0] d, logic [1:0] ln, string tag);
    step(1, 1, 0, 1, 0, 1, ln, a, d, 0, tag);
  endtask
  task automatic rd(logic [7:0] a, string tag);
    step(1, 1, 0, 1, 0, 0, 2'b11, a, 18'h0, 0, tag);
  endtask
  task automatic nop(string tag, bit oen);
    step(1, 1, 1, 1, 0, 0, 2'b11, 8'h0, 18'h0, oen, tag);
  endtask
  task automatic stl(logic [7:0] a, string tag);
    step(0, 1, 0, 1, 0, 1, 2'b00, a, 18'h3FFFF, 0, tag);
  endtask
  task automatic adv(logic [1:0] ln, logic [17:0] d, string tag);
    step(1, 0, 1, 0, 1, 0, ln, 8'h0, d, 0, tag);
  endtask
  task automatic flush(string tag);
    nop(tag, 0); nop(tag, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(dq_oe_o == 1'b0, "R10", {17'b0, dq_oe_o}, 18'h0);
    chk(dq_o == 18'h0, "R10", dq_o, 18'h0);
  endtask

  task automatic t_basic();
    wr(8'h10, 18'h12345, 2'b00, "R3");
    wr(8'h11, 18'h30F0F, 2'b00, "R3");
    rd(8'h10, "R2");
    rd(8'h11, "R2");
    flush("R2");
  endtask

  task automatic t_alternate();
    wr(8'h20, 18'h0A0A0, 2'b00, "R4");
    rd(8'h20, "R4");
    wr(8'h21, 18'h0B0B0, 2'b00, "R4");
    rd(8'h20, "R4");
    rd(8'h21, "R4");
    wr(8'h20, 18'h0C0C0, 2'b00, "R4");
    wr(8'h20, 18'h0D0D0, 2'b00, "R4");
    rd(8'h20, "R4");
    rd(8'h21, "R4");
    rd(8'h10, "R4");
    flush("R4");
  endtask

  task automatic t_lanes();
    wr(8'h30, 18'h2AAAA, 2'b00, "R5");
    flush("R5");
    wr(8'h30, 18'h15555, 2'b10, "R5");
    flush("R5");
    rd(8'h30, "R5");
    wr(8'h30, 18'h1FE01, 2'b01, "R5");
    wr(8'h31, 18'h00001, 2'b00, "R5");
    rd(8'h30, "R5");
    wr(8'h30, 18'h00000, 2'b11, "R5");
    flush("R5");
    rd(8'h30, "R5");
    flush("R5");
  endtask

  task automatic t_merge();
    wr(8'h40, 18'h00000, 2'b00, "R6");
    wr(8'h41, 18'h3FFFF, 2'b00, "R6");
    wr(8'h40, 18'h11111, 2'b10, "R6");
    wr(8'h40, 18'h22222, 2'b01, "R6");
    rd(8'h40, "R6");
    wr(8'h40, 18'h33333, 2'b00, "R6");
    wr(8'h40, 18'h04444, 2'b01, "R6");
    rd(8'h40, "R6");
    rd(8'h41, "R6");
    flush("R6");
  endtask

  task automatic t_deselect();
    wr(8'h50, 18'h15A5A, 2'b00, "R1");
    step(1, 1, 1, 1, 0, 1, 2'b00, 8'h50, 18'h00001, 0, "R1");
    step(1, 1, 0, 0, 0, 1, 2'b00, 8'h50, 18'h00002, 0, "R1");
    step(1, 1, 0, 1, 1, 1, 2'b00, 8'h50, 18'h00003, 0, "R1");
    adv(2'b00, 18'h00004, "R1");
    step(1, 1, 1, 0, 1, 0, 2'b11, 8'h50, 18'h0, 0, "R1");
    rd(8'h50, "R1");
    flush("R1");
  endtask

  task automatic t_stall();
    wr(8'h61, 18'h26161, 2'b00, "R7");
    wr(8'h60, 18'h16060, 2'b00, "R7");
    stl(8'h61, "R7");
    rd(8'h60, "R7");
    stl(8'h61, "R7");
    stl(8'h61, "R7");
    nop("R7", 0);
    stl(8'h61, "R7");
    nop("R7", 0);
    rd(8'h61, "R7");
    flush("R7");
  endtask

  task automatic t_oe();
    rd(8'h10, "R8");
    nop("R8", 0);
    nop("R8", 1);
    rd(8'h11, "R8");
    nop("R8", 0);
    nop("R8", 0);
  endtask

  task automatic t_burst();
    wr(8'h72, 18'h00072, 2'b00, "R9");
    adv(2'b00, 18'h00073, "R9");
    adv(2'b00, 18'h00070, "R9");
    adv(2'b00, 18'h00071, "R9");
    wr(8'h74, 18'h3C3C3, 2'b00, "R9");
    wr(8'h6F, 18'h1E1E1, 2'b00, "R9");
    rd(8'h73, "R9");
    adv(2'b11, 18'h0, "R9");
    adv(2'b11, 18'h0, "R9");
    adv(2'b11, 18'h0, "R9");
    adv(2'b11, 18'h0, "R9");
    rd(8'h74, "R9");
    rd(8'h6F, "R9");
    flush("R9");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    @(posedge clk);
    t_basic();
    t_alternate();
    t_lanes();
    t_merge();
    t_deselect();
    t_stall();
    t_oe();
    t_burst();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 18'h0, 18'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule